// File: doc/BRIEF.md
# Multi-Channel Sync Pulse Router

This block takes a small set of asynchronous external sync pins and turns each rising edge into a clean, single-cycle pulse. It then routes those pulses to a set of processing channels. Each channel chooses one pin through its own selector. A chosen pulse, gated by the channel's enable, raises a one-cycle `start` strobe, a one-cycle `hop` strobe, or both. The downstream start and hop datapaths consume these strobes.

Each channel holds a local configuration word that is written through a simple write port. The word contains the pin select, the enable, the start and hop action bits, and a first-only flag. A global control register can set the enable, start, hop and first-only bits of every channel in one write. A global write leaves each channel's pin select as it was. In first-only mode a channel acts on the first qualifying pulse and ignores every later pulse. This continues until its configuration is written again.

Top module: `sync_pulse_router`

## Requirements
- R1: After reset all strobes are low, `glob_rdata` reads zero, every channel flag is clear, and channel i selects pin i (modulo the pin count).
- R2: A rising edge on a pin yields exactly one strobe per affected channel, however long the pin stays high. Strobes are never high on two consecutive cycles.
- R3: The channel word places the pin select in bits [1:0]. A channel responds only to the pin it selects, and edges on other pins have no effect on it.
- R4: Channel word bit 2 is the sync enable. When it is clear, the channel issues neither a start strobe nor a hop strobe.
- R5: Channel word bit 3 enables the start action. An enabled pulse raises `start_strobe` only when this bit is set.
- R6: Channel word bit 4 enables the hop action. An enabled pulse raises `hop_strobe` only when this bit is set.
- R7: When channel word bit 5 (first-only) is set, only the first enabled pulse fires and later pulses are ignored. When bit 5 is clear, every pulse fires.
- R8: A write to a channel's word clears that channel's first-only latch. A write to a different channel's word leaves the latch unchanged.
- R9: A global write does three things in every channel. It sets channel i's enable from global bit i. It sets the start, hop and first-only bits from global bits 4, 5 and 6. It clears the first-only latch. Pin selects are left unchanged.
- R10: `glob_rdata` returns bits 6:0 of the last global write one cycle later. Bit 7 is reserved and always reads zero.
- R11: Suppose a pin is first sampled high at clock edge k. The strobe is then high from edge k+2 to edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pins | input | NUM_PINS | Asynchronous external sync inputs |
| glob_we | input | 1 | Global control register write strobe |
| glob_wdata | input | NUM_CH+4 | Global write data: enables, start, hop, first-only, reserved |
| glob_rdata | output | NUM_CH+4 | Global control register readback |
| ch_we | input | 1 | Channel word write strobe |
| ch_wsel | input | clog2(NUM_CH) | Channel addressed by the write |
| ch_wdata | input | clog2(NUM_PINS)+4 | Channel word: select, enable, start, hop, first-only |
| start_strobe | output | NUM_CH | One-cycle start pulse per channel |
| hop_strobe | output | NUM_CH | One-cycle hop pulse per channel |

## Verification
The bench builds the block with its default four pins, four channels and a two-stage synchronizer. With these values the global word is exactly eight bits wide, so the reserved top bit can be observed. Every pin and every channel can also be paired with every other, so any pin can be routed to any channel or to several channels at once. The two-stage depth fixes the pin-to-strobe latency at a known cycle count, and the bench samples at exactly that edge.

// File: rtl/syncdist_pkg.sv
package syncdist_pkg;

    // Per-channel action flags; en sits in the least significant position.
    typedef struct packed {
        logic first;
        logic hop;
        logic start;
        logic en;
    } sync_flags_t;

    localparam int FLAG_W = $bits(sync_flags_t);

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sh   = {state_q.sh[STAGES-2:0], pin};
        state_d.prev = state_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise = state_q.sh[STAGES-1] & ~state_q.prev;

endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
    import syncdist_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CH_IDX   = 0,
    localparam int SEL_W   = $clog2(NUM_PINS),
    localparam int CW      = SEL_W + FLAG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_rise,
    input  logic                loc_we,
    input  logic [CW-1:0]       loc_wdata,
    input  logic                glob_we,
    input  sync_flags_t         glob_flags,
    output logic                start_stb,
    output logic                hop_stb
);

    localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(CH_IDX % NUM_PINS);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        sync_flags_t      flags;
        logic             seen;
        logic             start;
        logic             hop;
    } state_t;

    state_t state_d, state_q;
    logic   picked;
    logic   fire;

    always_comb begin
        picked = 1'b0;
        if ({1'b0, state_q.sel} < (SEL_W+1)'(NUM_PINS))
            picked = pin_rise[state_q.sel];
        fire = picked & state_q.flags.en & ~(state_q.flags.first & state_q.seen);

        state_d       = state_q;
        state_d.start = fire & state_q.flags.start;
        state_d.hop   = fire & state_q.flags.hop;
        if (fire) state_d.seen = 1'b1;

        if (loc_we) begin
            state_d.sel   = loc_wdata[SEL_W-1:0];
            state_d.flags = sync_flags_t'(loc_wdata[SEL_W +: FLAG_W]);
            state_d.seen  = 1'b0;
        end else if (glob_we) begin
            state_d.flags = glob_flags;
            state_d.seen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.sel <= SEL_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_stb = state_q.start;
    assign hop_stb   = state_q.hop;

endmodule

// File: rtl/sync_pulse_router.sv
module sync_pulse_router
    import syncdist_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_PINS),
    localparam int CW         = SEL_W + FLAG_W,
    localparam int GW         = NUM_CH + FLAG_W,
    localparam int CH_AW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_pins,
    input  logic                glob_we,
    input  logic [GW-1:0]       glob_wdata,
    output logic [GW-1:0]       glob_rdata,
    input  logic                ch_we,
    input  logic [CH_AW-1:0]    ch_wsel,
    input  logic [CW-1:0]       ch_wdata,
    output logic [NUM_CH-1:0]   start_strobe,
    output logic [NUM_CH-1:0]   hop_strobe
);

    localparam int START_BIT = NUM_CH;
    localparam int HOP_BIT   = NUM_CH + 1;
    localparam int FIRST_BIT = NUM_CH + 2;

    typedef struct packed {
        logic [GW-2:0] ctrl;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (glob_we) state_d.ctrl = glob_wdata[GW-2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign glob_rdata = {1'b0, state_q.ctrl};

    logic [NUM_PINS-1:0] pin_rise;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (sync_pins[p]),
            .rise (pin_rise[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sync_flags_t gflags;
        logic        sel_hit;

        always_comb begin
            gflags.en    = glob_wdata[c];
            gflags.start = glob_wdata[START_BIT];
            gflags.hop   = glob_wdata[HOP_BIT];
            gflags.first = glob_wdata[FIRST_BIT];
            sel_hit      = ch_we && (ch_wsel == CH_AW'(c));
        end

        chan_sync_ctrl #(.NUM_PINS(NUM_PINS), .CH_IDX(c)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_rise  (pin_rise),
            .loc_we    (sel_hit),
            .loc_wdata (ch_wdata),
            .glob_we   (glob_we),
            .glob_flags(gflags),
            .start_stb (start_strobe[c]),
            .hop_stb   (hop_strobe[c])
        );
    end

endmodule

// File: rtl/sync_pulse_router_chk.sv
module sync_pulse_router_chk #(
    parameter int NUM_CH = 4,
    parameter int GW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glob_we,
    input logic [GW-1:0]     glob_wdata,
    input logic [GW-1:0]     glob_rdata,
    input logic [NUM_CH-1:0] start_strobe,
    input logic [NUM_CH-1:0] hop_strobe
);

    localparam logic [GW-1:0] RD_MASK = {1'b0, {(GW-1){1'b1}}};

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rdata[GW-1] == 1'b0);

    assert_glob_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        glob_we |=> glob_rdata == ($past(glob_wdata) & RD_MASK));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_strobe[c] |=> !start_strobe[c]);
        assert_hop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hop_strobe[c] |=> !hop_strobe[c]);
    end

endmodule

bind sync_pulse_router sync_pulse_router_chk #(.NUM_CH(NUM_CH), .GW(GW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glob_we     (glob_we),
    .glob_wdata  (glob_wdata),
    .glob_rdata  (glob_rdata),
    .start_strobe(start_strobe),
    .hop_strobe  (hop_strobe)
);

// File: tb/sim_sync_pulse_router.sv
module sim_sync_pulse_router;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sync_pins = '0;
    logic       glob_we = 1'b0;
    logic [7:0] glob_wdata = '0;
    logic [7:0] glob_rdata;
    logic       ch_we = 1'b0;
    logic [1:0] ch_wsel = '0;
    logic [5:0] ch_wdata = '0;
    logic [3:0] start_strobe;
    logic [3:0] hop_strobe;

    int checks = 0;
    int fails = 0;
    int sc[4];
    int hc[4];

    always #2 clk = ~clk;

    sync_pulse_router u0 (
        .clk(clk), .rst_n(rst_n), .sync_pins(sync_pins),
        .glob_we(glob_we), .glob_wdata(glob_wdata), .glob_rdata(glob_rdata),
        .ch_we(ch_we), .ch_wsel(ch_wsel), .ch_wdata(ch_wdata),
        .start_strobe(start_strobe), .hop_strobe(hop_strobe)
    );

    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            sc[c] += int'(start_strobe[c]);
            hc[c] += int'(hop_strobe[c]);
        end
    end

    // Row: {channel, channel word, pin, pulses, expected starts, expected hops}
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 6'h0C, 2'd0, 2'd2, 2'd2, 2'd0},  // R2 R5: every pulse starts
        {2'd1, 6'h16, 2'd2, 2'd2, 2'd0, 2'd2},  // R3 R6: pin 2 drives hop
        {2'd2, 6'h3D, 2'd1, 2'd3, 2'd1, 2'd1},  // R7: first-only
        {2'd3, 6'h1B, 2'd3, 2'd2, 2'd0, 2'd0},  // R4: disabled channel
        {2'd0, 6'h0D, 2'd0, 2'd2, 2'd0, 2'd0},  // R3: unselected pin ignored
        {2'd2, 6'h3D, 2'd1, 2'd2, 2'd1, 2'd1}   // R8: rewrite clears latch
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        for (int c = 0; c < 4; c++) begin
            sc[c] = 0;
            hc[c] = 0;
        end
    endtask

    task automatic wr_ch(input logic [1:0] c, input logic [5:0] d);
        @(negedge clk);
        ch_we = 1'b1; ch_wsel = c; ch_wdata = d;
        @(negedge clk);
        ch_we = 1'b0;
    endtask

    task automatic wr_glob(input logic [7:0] d);
        @(negedge clk);
        glob_we = 1'b1; glob_wdata = d;
        @(negedge clk);
        glob_we = 1'b0;
    endtask

    task automatic pulse(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sync_pins[p] = 1'b1;
            repeat (3) @(negedge clk);
            sync_pins[p] = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(start_strobe == 4'h0, "R1 start reset", int'(start_strobe), 0);
        chk(hop_strobe == 4'h0, "R1 hop reset", int'(hop_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(glob_rdata == 8'h00, "R1 glob reset", int'(glob_rdata), 0);

        // R9 R1: global enable + start; default select routes pin 2 to channel 2
        wr_glob(8'h1F);
        chk(glob_rdata == 8'h1F, "R10 readback", int'(glob_rdata), 8'h1F);
        clr();
        pulse(2, 1);
        for (int c = 0; c < 4; c++) begin
            chk(sc[c] == ((c == 2) ? 1 : 0), "R9 R1 mirror start", sc[c], (c == 2) ? 1 : 0);
            chk(hc[c] == 0, "R9 no hop", hc[c], 0);
        end

        // R10: reserved bit reads zero; R9 first-only mirrored
        wr_glob(8'hFF);
        chk(glob_rdata == 8'h7F, "R10 reserved", int'(glob_rdata), 8'h7F);
        clr();
        pulse(1, 2);
        for (int c = 0; c < 4; c++) begin
            chk(sc[c] == ((c == 1) ? 1 : 0), "R9 first start", sc[c], (c == 1) ? 1 : 0);
            chk(hc[c] == ((c == 1) ? 1 : 0), "R9 first hop", hc[c], (c == 1) ? 1 : 0);
        end

        // Table walk
        for (int r = 0; r < 6; r++) begin
            logic [15:0] v;
            v = VEC[r];
            wr_ch(v[15:14], v[13:8]);
            clr();
            pulse(int'(v[7:6]), int'(v[5:4]));
            chk(sc[v[15:14]] == int'(v[3:2]), $sformatf("R%0d-row%0d start", r, r),
                sc[v[15:14]], int'(v[3:2]));
            chk(hc[v[15:14]] == int'(v[1:0]), $sformatf("R%0d-row%0d hop", r, r),
                hc[v[15:14]], int'(v[1:0]));
        end

        // R8: write to another channel leaves channel 2 latched
        wr_ch(2'd1, 6'h16);
        clr();
        pulse(1, 1);
        chk(sc[2] == 0, "R8 other channel write", sc[2], 0);
        chk(hc[2] == 0, "R8 other channel hop", hc[2], 0);

        // R11: latency and width on channel 0
        wr_ch(2'd0, 6'h0C);
        repeat (2) @(negedge clk);
        sync_pins[0] = 1'b1;
        @(posedge clk);           // edge k
        @(posedge clk); #1;       // edge k+1
        chk(start_strobe[0] == 1'b0, "R11 early", int'(start_strobe[0]), 0);
        @(posedge clk); #1;       // edge k+2
        chk(start_strobe[0] == 1'b1, "R11 on time", int'(start_strobe[0]), 1);
        @(posedge clk); #1;       // edge k+3
        chk(start_strobe[0] == 1'b0, "R11 R2 width", int'(start_strobe[0]), 0);
        @(negedge clk);
        sync_pins[0] = 1'b0;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule